// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block sits beside a small processor core and decides which interrupt, if any, the core takes at its next instruction boundary. Each of its sources is fixed at build time as either an event source, whose request is caught in a stored pending flag, or a level source, which requests only while its input is high and stores nothing. A source can win only when its own enable input and the controller's global enable are both 1. Among the sources that qualify, the lowest index wins.

When the core signals an instruction boundary and a request qualifies, the controller raises a one-cycle accept pulse and drives the vector address in the same cycle. On the following clock edge it clears the global enable and the winner's pending flag. Software sets and clears the global enable with two command strobes. A return-from-handler strobe sets the global enable again, but it also makes the core run one more instruction of the interrupted program before the next request is served. A select input moves the vector table from address zero to a configurable boot base.

Top module: `irq_vec_ctrl`

## Requirements
- R1: When several sources qualify, the source with the lowest index is accepted. Table slot 0 belongs to reset, so source i uses table slot i+1.
- R2: A source is accepted only when its bit of `src_en_i` is 1, the global enable `gie_o` is 1, and `boundary_i` is 1. `accept_o` is high for exactly that cycle.
- R3: In the clock cycle after an accept, `gie_o` is 0. `gie_set_i` and `reti_i` each set it to 1 on the next edge. It resets to 0.
- R4: For an event source, a 1 on `src_i` sets its bit of `pend_o` on the next edge. The flag is kept while the source enable or the global enable is 0, and it is served once both are 1.
- R5: An event flag is cleared on the edge after its source is accepted, or on the edge after a 1 on its bit of `clr_w1c_i`. A 0 on `clr_w1c_i` leaves the flag as it is. If a new event arrives in the same cycle as a clear, the flag stays set.
- R6: A level source has no flag, and its bit of `pend_o` is always 0. It requests only while `src_i` is 1. A level that drops before the controller is enabled causes no accept.
- R7: After `reti_i`, the first boundary gives no accept. The next boundary may accept. No accept occurs in the cycle of `reti_i` itself.
- R8: In a cycle where `gie_clr_i` is 1, no accept occurs, even if a request qualifies in that same cycle. `gie_clr_i` wins over `gie_set_i`.
- R9: `vec_addr_o` = base + 2*(i+1) for winning source i. The base is 0 when `vec_boot_i` is 0 and BOOT_BASE when it is 1.
- R10: After reset, `accept_o` is 0 and `pend_o` is all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Event pulses or level requests, one bit per source |
| src_en_i | input | NUM_SRC | Per-source enable |
| clr_w1c_i | input | NUM_SRC | Write-one-to-clear strobes for the pending flags |
| gie_set_i | input | 1 | Global enable set command |
| gie_clr_i | input | 1 | Global enable clear command, effective at once |
| reti_i | input | 1 | Return-from-handler strobe |
| boundary_i | input | 1 | Core is at an instruction boundary |
| vec_boot_i | input | 1 | Relocate the vector table to BOOT_BASE |
| accept_o | output | 1 | One-cycle accept pulse |
| vec_addr_o | output | ADDR_W | Vector address of the accepted source |
| gie_o | output | 1 | Global enable state |
| pend_o | output | NUM_SRC | Stored event flags |

## Verification
The hardest state to reach is the one-instruction gap. Getting there takes an accept, a return strobe at a boundary, and then a request that is still pending with both enables set. The bench builds this with two stored event flags. It takes the first one, issues the return, and checks three boundaries in a row: blocked, blocked, then the second vector. Beyond that, the bench sweeps every combination of event pattern, level state, per-source enables and table select on a four-source build. For each case it derives the winner and vector arithmetically.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Control state kept by the gate: global enable and post-return gap.
  typedef struct packed {
    logic gie;
    logic gap;
  } irq_ctl_t;
endpackage

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int          NUM_SRC    = 4,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] w1c_i,
  input  logic [NUM_SRC-1:0] take_i,
  output logic [NUM_SRC-1:0] flag_o,
  output logic [NUM_SRC-1:0] raw_req_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (LEVEL_MASK[i]) begin : g_level
      assign flag_o[i]    = 1'b0;
      assign raw_req_o[i] = src_i[i];
    end else begin : g_event
      logic flag_q, flag_d;
      always_comb begin
        flag_d = flag_q;
        if (w1c_i[i] || take_i[i]) flag_d = 1'b0;
        if (src_i[i])              flag_d = 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
      end
      assign flag_o[i]    = flag_q;
      assign raw_req_o[i] = flag_q;

      AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !w1c_i[i] && !take_i[i]) |=> flag_q); // R4
      AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((w1c_i[i] || take_i[i]) && !src_i[i]) |=> !flag_q); // R5
      AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        src_i[i] |=> flag_q); // R5
    end
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int NUM_SRC = 4,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [NUM_SRC-1:0] grant_o
);
  always_comb begin
    idx_o   = '0;
    grant_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o   = IDX_W'(i);
        grant_o = '0;
        grant_o[i] = 1'b1;
      end
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic boundary_i,
  input  logic any_i,
  input  logic gie_set_i,
  input  logic gie_clr_i,
  input  logic reti_i,
  output logic accept_o,
  output logic gie_o
);
  irq_ctl_t ctl_q, ctl_d;

  assign accept_o = boundary_i && ctl_q.gie && !ctl_q.gap && !gie_clr_i
                    && !reti_i && any_i;
  assign gie_o    = ctl_q.gie;

  always_comb begin
    ctl_d = ctl_q;
    if (accept_o || gie_clr_i)    ctl_d.gie = 1'b0;
    else if (gie_set_i || reti_i) ctl_d.gie = 1'b1;
    if (reti_i)                   ctl_d.gap = 1'b1;
    else if (boundary_i)          ctl_d.gap = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  AST_DISABLE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr_i |-> !accept_o); // R8
  AST_ACCEPT_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> !gie_o); // R3
  AST_RETI_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    reti_i |=> !accept_o); // R7
  AST_CLR_BEATS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr_i |=> !gie_o); // R8
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int                 NUM_SRC    = 4,
  parameter int                 ADDR_W     = 12,
  parameter logic [ADDR_W-1:0]  BOOT_BASE  = 12'hC00,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 4'b1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic [NUM_SRC-1:0] clr_w1c_i,
  input  logic               gie_set_i,
  input  logic               gie_clr_i,
  input  logic               reti_i,
  input  logic               boundary_i,
  input  logic               vec_boot_i,
  output logic               accept_o,
  output logic [ADDR_W-1:0]  vec_addr_o,
  output logic               gie_o,
  output logic [NUM_SRC-1:0] pend_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] raw_req, req, grant, take;
  logic [IDX_W-1:0]   win_idx;
  logic               any_req;
  logic [ADDR_W-1:0]  tbl_base;

  irq_flags #(.NUM_SRC(NUM_SRC), .LEVEL_MASK(LEVEL_MASK)) u_flags (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .w1c_i(clr_w1c_i),
    .take_i(take), .flag_o(pend_o), .raw_req_o(raw_req));

  assign req = raw_req & src_en_i;

  irq_prio #(.NUM_SRC(NUM_SRC)) u_prio (
    .req_i(req), .any_o(any_req), .idx_o(win_idx), .grant_o(grant));

  irq_gate u_gate (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .any_i(any_req),
    .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i), .reti_i(reti_i),
    .accept_o(accept_o), .gie_o(gie_o));

  assign take       = grant & {NUM_SRC{accept_o}};
  assign tbl_base   = vec_boot_i ? BOOT_BASE : '0;
  assign vec_addr_o = tbl_base + (ADDR_W'(win_idx) + ADDR_W'(1)) * ADDR_W'(2);

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> ($countones(take) == 1)); // R1
  AST_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> ((take & ~src_en_i) == '0)); // R2
  AST_LEVEL_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && ((take & LEVEL_MASK) != '0)) |-> ((take & src_i) != '0)); // R6
  AST_LEVEL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o & LEVEL_MASK) == '0); // R6
  AST_ACCEPT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> !accept_o); // R2
endmodule

// File: tb/sim_irq_vec_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vec_ctrl;
  localparam int N = 4;
  localparam logic [11:0] BOOT = 12'hC00;

  logic clk, rst_n;
  logic [N-1:0] src, en, w1c;
  logic gset, gclr, reti, bnd, vsel;
  logic accept, gie;
  logic [11:0] vec;
  logic [N-1:0] pend;
  int n_chk, n_fail;
  bit done;

  irq_vec_ctrl #(.NUM_SRC(N), .ADDR_W(12), .BOOT_BASE(BOOT), .LEVEL_MASK(4'b1000)) u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .src_en_i(en), .clr_w1c_i(w1c),
    .gie_set_i(gset), .gie_clr_i(gclr), .reti_i(reti), .boundary_i(bnd),
    .vec_boot_i(vsel), .accept_o(accept), .vec_addr_o(vec), .gie_o(gie),
    .pend_o(pend));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic idle();
    src = '0; w1c = '0; gset = 0; gclr = 0; reti = 0; bnd = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idle();
  endtask

  function automatic int winner(input logic [N-1:0] r);
    for (int i = 0; i < N; i++) if (r[i]) return i;
    return -1;
  endfunction

  task automatic trial(input logic [2:0] p, input bit lv, input logic [N-1:0] e, input bit s);
    logic [N-1:0] r;
    int w;
    gclr = 1; w1c = '1;            step();
    src = {1'b0, p};               step();
    src = {lv, 3'b000}; en = e; gset = 1; vsel = s; step();
    chk(pend == {1'b0, p}, "R4", pend, {1'b0, p});
    src = {lv, 3'b000}; bnd = 1; #1;
    r = ({lv, p}) & e;
    w = winner(r);
    if (w < 0) chk(!accept, "R2", accept, 0);
    else begin
      chk(accept, "R1", accept, 1);
      chk(vec == (s ? BOOT : 12'h0) + 12'(2 * (w + 1)), "R9", vec,
          (s ? BOOT : 12'h0) + 12'(2 * (w + 1)));
    end
    step();
    if (w >= 0) begin
      chk(!gie, "R3", gie, 0);
      if (w < 3) chk(!pend[w], "R5", pend, 0);
    end
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    idle(); en = '0; vsel = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!accept && pend == '0, "R10", {accept, pend}, 0);
    chk(!gie, "R3", gie, 0);
    rst_n = 1;
    @(negedge clk);

    for (int s = 0; s < 2; s++)
      for (int lv = 0; lv < 2; lv++)
        for (int p = 0; p < 8; p++)
          for (int e = 0; e < 16; e++)
            trial(3'(p), lv[0], 4'(e), s[0]);

    // R5: write-one-to-clear removes a stored flag, and write-zero keeps it
    gclr = 1; w1c = '1; step();
    src = 4'b0011; step();
    w1c = 4'b0000; step();
    chk(pend == 4'b0011, "R5", pend, 4'b0011);
    w1c = 4'b0010; step();
    chk(pend == 4'b0001, "R5", pend, 4'b0001);
    // R5: an event in the same cycle as a clear keeps the flag
    w1c = 4'b0001; src = 4'b0001; step();
    chk(pend == 4'b0001, "R5", pend, 4'b0001);

    // R6: a level that drops before enabling is lost
    w1c = '1; step();
    en = '1; src = 4'b1000; step();
    src = 4'b0000; gset = 1; step();
    bnd = 1; #1;
    chk(!accept, "R6", accept, 0);
    step();

    // R8: the clear command blocks an accept in its own cycle
    src = 4'b0100; step();
    bnd = 1; gclr = 1; #1;
    chk(!accept, "R8", accept, 0);
    step();
    chk(!gie && pend[2], "R8", {gie, pend}, 4'b0100);
    gset = 1; gclr = 1; step();
    chk(!gie, "R8", gie, 0);

    // R7: one instruction runs after a return before the next service
    w1c = '1; step();
    src = 4'b0101; gset = 1; vsel = 0; step();
    bnd = 1; #1;
    chk(accept && vec == 12'd2, "R1", vec, 2);
    step();
    reti = 1; bnd = 1; #1;
    chk(!accept, "R7", accept, 0);
    step();
    chk(gie, "R3", gie, 1);
    bnd = 1; #1;
    chk(!accept, "R7", accept, 0);
    step();
    bnd = 1; #1;
    chk(accept && vec == 12'd6, "R7", vec, 6);
    step();
    chk(pend == 4'b0000, "R5", pend, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule